// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block is the MAC-side transmit path of a 100 Mb/s reduced media-independent interface link. It runs on the 50 MHz reference clock and reads frame bytes from a valid/ready byte stream. Each byte carries a flag that marks the end of the frame. For every frame the block first sends a preamble it makes itself and the start-of-frame delimiter. It then sends the payload two bits per clock on the transmit data pair, and drives the transmit enable line to frame those symbols.

The serializer adds no frame check sequence and no padding. The upstream logic supplies every payload byte and marks the final one. If the upstream stream has no byte ready when one is needed in mid-frame, the block ends the frame cleanly at the byte boundary and raises an underrun pulse. Between frames it holds the line idle for the interframe gap.

Top module: `rmii_tx_serializer`

## Requirements
- R1: During and right after a synchronous active-high reset, tx_en, txd, s_ready and tx_underrun are all zero.
- R2: When the line is idle, the gap has elapsed and s_valid is sampled high at a rising edge, tx_en rises on that edge and the first dibit driven is 01.
- R3: Every frame starts with seven bytes of 0x55 followed by one byte of 0xD5, which makes 32 dibits before the first payload dibit.
- R4: Each byte goes out over four consecutive cycles, bits [1:0] first, then [3:2], [5:4] and [7:6], with txd[0] carrying the lower bit of each pair.
- R5: tx_en stays high with no break for exactly 4*(8+N) cycles for a frame of N payload bytes. It falls on the edge right after the final dibit.
- R6: txd is 00 in every cycle in which tx_en is low.
- R7: s_ready is high for one cycle in each four-cycle byte slot, during the final dibit of the SFD or of a payload byte that is not the last. It is never high while tx_en is low. A byte is taken at a rising edge where s_valid and s_ready are both high.
- R8: Between two frames tx_en stays low for at least 24 cycles. When the next frame is already waiting, the gap is exactly 24 cycles.
- R9: If s_valid is low while s_ready is high, the frame ends after the current byte. tx_underrun then pulses for one cycle, in the first cycle with tx_en low. Every byte sent before that point is intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | 8 | Payload byte from the upstream stream |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | The byte on s_data is the last one of the frame |
| s_ready | output | 1 | The block takes s_data at the next rising edge |
| txd | output | 2 | Transmit dibit to the PHY |
| tx_en | output | 1 | Transmit enable |
| tx_underrun | output | 1 | One-cycle pulse when a frame is cut short for lack of data |

## Verification
The assertions check on every cycle that txd is zero while the line is idle, and that each enabled burst is a whole number of bytes and at least preamble-long. They also check that no idle stretch between frames is shorter than the gap, that s_ready is never high in two cycles in a row or outside a frame, and that an underrun pulse comes with the line going idle. Only the bench scenarios can show the actual symbol content. That covers the preamble and delimiter values, the order of the dibits within a byte, the exact payload for each frame length, the exact 24-cycle gap for back-to-back frames, and the underrun cases, including one with no payload at all.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2
  } tx_phase_t;

  localparam logic [7:0] PREAMBLE_OCTET = 8'h55;
  localparam logic [7:0] SFD_OCTET      = 8'hD5;
endpackage

// File: rtl/rmii_tx_gap_timer.sv
module rmii_tx_gap_timer #(
  parameter int IFG_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int GW = $clog2(IFG_CYCLES + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= GW'(IFG_CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/rmii_tx_ctrl.sv
module rmii_tx_ctrl
  import rmii_tx_pkg::*;
#(
  parameter int PREAMBLE_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       gap_done,
  output logic       frame_end,
  output logic       underrun_ev,
  output logic       active_n,
  output logic [1:0] dibit_n
);
  localparam int PCW = $clog2(PREAMBLE_BYTES + 1);
  localparam logic [PCW-1:0] PRE_LAST = PCW'(PREAMBLE_BYTES - 1);
  localparam logic [PCW-1:0] SFD_IDX  = PCW'(PREAMBLE_BYTES);

  tx_phase_t      phase_q, phase_n;
  logic [7:0]     byte_q, byte_n;
  logic [1:0]     d_q, d_n;
  logic [PCW-1:0] pcnt_q, pcnt_n;
  logic           last_q, last_n;
  logic           slot_end, take;

  assign slot_end = (d_q == 2'd3);
  assign s_ready  = slot_end &&
                    ((phase_q == PH_PRE && pcnt_q == SFD_IDX) ||
                     (phase_q == PH_DATA && !last_q));
  assign take     = s_ready && s_valid;

  always_comb begin
    phase_n     = phase_q;
    byte_n      = byte_q;
    d_n         = d_q;
    pcnt_n      = pcnt_q;
    last_n      = last_q;
    frame_end   = 1'b0;
    underrun_ev = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (s_valid && gap_done) begin
          phase_n = PH_PRE;
          byte_n  = PREAMBLE_OCTET;
          d_n     = 2'd0;
          pcnt_n  = '0;
          last_n  = 1'b0;
        end
      end
      PH_PRE: begin
        if (!slot_end) begin
          d_n = d_q + 2'd1;
        end else if (pcnt_q < SFD_IDX) begin
          pcnt_n = pcnt_q + 1'b1;
          d_n    = 2'd0;
          byte_n = (pcnt_q == PRE_LAST) ? SFD_OCTET : PREAMBLE_OCTET;
        end else if (take) begin
          phase_n = PH_DATA;
          byte_n  = s_data;
          last_n  = s_last;
          d_n     = 2'd0;
        end else begin
          phase_n     = PH_IDLE;
          frame_end   = 1'b1;
          underrun_ev = 1'b1;
        end
      end
      PH_DATA: begin
        if (!slot_end) begin
          d_n = d_q + 2'd1;
        end else if (take) begin
          byte_n = s_data;
          last_n = s_last;
          d_n    = 2'd0;
        end else begin
          phase_n     = PH_IDLE;
          frame_end   = 1'b1;
          underrun_ev = !last_q;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  assign active_n = (phase_n != PH_IDLE);
  assign dibit_n  = byte_n[{d_n, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      byte_q  <= '0;
      d_q     <= '0;
      pcnt_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      byte_q  <= byte_n;
      d_q     <= d_n;
      pcnt_q  <= pcnt_n;
      last_q  <= last_n;
    end
  end

  // R7: a byte slot offers one acceptance cycle only
  assert_ready_single_R7: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);
  // R7: no acceptance outside a frame
  assert_ready_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (phase_q != PH_IDLE));
endmodule

// File: rtl/rmii_tx_out.sv
module rmii_tx_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       active_n,
  input  logic [1:0] dibit_n,
  input  logic       underrun_ev,
  output logic       tx_en,
  output logic [1:0] txd,
  output logic       tx_underrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en       <= 1'b0;
      txd         <= 2'b00;
      tx_underrun <= 1'b0;
    end else begin
      tx_en       <= active_n;
      txd         <= active_n ? dibit_n : 2'b00;
      tx_underrun <= underrun_ev;
    end
  end
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int PREAMBLE_BYTES = 7,
  parameter int IFG_CYCLES     = 24,
  parameter int LEN_W          = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic [1:0] txd,
  output logic       tx_en,
  output logic       tx_underrun
);
  localparam int MIN_BURST = 4 * (PREAMBLE_BYTES + 1);

  logic       gap_done, frame_end, underrun_ev, active_n;
  logic [1:0] dibit_n;

  rmii_tx_ctrl #(.PREAMBLE_BYTES(PREAMBLE_BYTES)) ctrl_i (
    .clk(clk), .rst(rst),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .gap_done(gap_done), .frame_end(frame_end), .underrun_ev(underrun_ev),
    .active_n(active_n), .dibit_n(dibit_n)
  );

  rmii_tx_gap_timer #(.IFG_CYCLES(IFG_CYCLES)) gap_i (
    .clk(clk), .rst(rst), .start(frame_end), .done(gap_done)
  );

  rmii_tx_out out_i (
    .clk(clk), .rst(rst),
    .active_n(active_n), .dibit_n(dibit_n), .underrun_ev(underrun_ev),
    .tx_en(tx_en), .txd(txd), .tx_underrun(tx_underrun)
  );

  // Run-length observers used only by the assertions below
  logic [LEN_W-1:0] en_len_q, low_len_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_len_q  <= '0;
      low_len_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      if (tx_en) begin
        if (en_len_q != '1) en_len_q <= en_len_q + 1'b1;
        low_len_q <= '0;
        seen_q    <= 1'b1;
      end else begin
        en_len_q <= '0;
        if (low_len_q != '1) low_len_q <= low_len_q + 1'b1;
      end
    end
  end

  // R6: idle line carries zeros
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (txd == 2'b00));
  // R5: every burst is whole bytes and at least preamble plus delimiter
  assert_whole_bytes_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> (en_len_q[1:0] == 2'b00 && en_len_q >= LEN_W'(MIN_BURST)));
  // R8: interframe gap honoured
  assert_gap_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && seen_q) |-> (low_len_q >= LEN_W'(IFG_CYCLES)));
  // R9: underrun pulse coincides with the line going idle
  assert_underrun_close_R9: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> (!tx_en && $past(tx_en)));
  // R9: the pulse lasts one cycle
  assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> !tx_underrun);
endmodule

// File: tb/rmii_tx_serializer_tb_top.sv
module rmii_tx_serializer_tb_top;
  localparam int IFG = 24;
  localparam int NF  = 6;
  // {payload length, seed}
  localparam logic [15:0] FRAMES [NF] = '{
    16'h01_A7, 16'h02_00, 16'h05_FF, 16'h03_1E, 16'h0C_C3, 16'h04_5A
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [1:0] txd;
  logic       tx_en;
  logic       tx_underrun;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [1:0] rx_d [256];
  int nd = 0;
  int ur_cnt = 0;
  int idle_bad = 0;
  int low_run = 0;
  int last_gap = -1;
  bit seen = 1'b0;

  always #5 clk = ~clk;

  rmii_tx_serializer dut_i (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .txd(txd), .tx_en(tx_en), .tx_underrun(tx_underrun)
  );

  always @(negedge clk) begin
    if (rst) begin
      seen    = 1'b0;
      low_run = 0;
    end else begin
      if (tx_en) begin
        if (low_run != 0 && seen) last_gap = low_run;
        low_run = 0;
        seen    = 1'b1;
        if (nd < 256) rx_d[nd] = txd;
        nd++;
      end else begin
        low_run++;
        if (txd != 2'b00) idle_bad++;
      end
      if (tx_underrun) ur_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input logic [7:0] s, input int k);
    return s ^ 8'(k * 59);
  endfunction

  function automatic logic [7:0] rx_byte(input int i);
    return {rx_d[4*i+3], rx_d[4*i+2], rx_d[4*i+1], rx_d[4*i]};
  endfunction

  task automatic check_frame(input int n, input logic [7:0] seed,
                             input int ur_before, input bit exp_ur,
                             input bit chk_gap);
    bit ok;
    chk(nd == 4 * (8 + n), "R5", "enabled dibit count", nd, 4 * (8 + n));
    chk(rx_d[0] == 2'b01, "R2", "first dibit", int'(rx_d[0]), 1);
    ok = 1'b1;
    for (int i = 0; i < 7; i++) if (rx_byte(i) != 8'h55) ok = 1'b0;
    if (rx_byte(7) != 8'hD5) ok = 1'b0;
    chk(ok, "R3", "preamble/SFD bytes", int'(rx_byte(7)), 32'hD5);
    for (int k = 0; k < n; k++)
      chk(rx_byte(8 + k) == pay(seed, k), "R4", "payload byte",
          int'(rx_byte(8 + k)), int'(pay(seed, k)));
    chk((ur_cnt - ur_before) == int'(exp_ur), "R9", "underrun pulses",
        ur_cnt - ur_before, int'(exp_ur));
    if (chk_gap) chk(last_gap == IFG, "R8", "interframe gap", last_gap, IFG);
    nd = 0;
  endtask

  // cut > 0: send cut bytes without last, then stop supplying data
  task automatic send_frame(input int len, input logic [7:0] seed,
                            input int cut, input bit chk_gap);
    int n;
    int urb;
    n   = (cut > 0) ? cut : len;
    urb = ur_cnt;
    for (int k = 0; k < n; k++) begin
      s_data  = pay(seed, k);
      s_last  = (cut == 0) && (k == len - 1);
      s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    while (tx_en) @(negedge clk);
    @(negedge clk);
    check_frame(n, seed, urb, cut > 0, chk_gap);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int urb;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(!tx_en && txd == 2'b00 && !s_ready && !tx_underrun, "R1",
        "outputs in reset", {tx_en, txd, s_ready, tx_underrun}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_en && txd == 2'b00 && !s_ready, "R1", "outputs after reset",
        {tx_en, txd, s_ready}, 0);

    // vector table, frames back to back
    for (int f = 0; f < NF; f++)
      send_frame(int'(FRAMES[f][15:8]), FRAMES[f][7:0], 0, f != 0);

    // R9: underrun after three payload bytes
    repeat (30) @(negedge clk);
    send_frame(8, 8'h81, 3, 1'b0);

    // R9: underrun with no payload byte at all
    repeat (30) @(negedge clk);
    urb = ur_cnt;
    s_data = 8'h11; s_last = 1'b0; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    while (!tx_en) @(negedge clk);
    while (tx_en) @(negedge clk);
    @(negedge clk);
    check_frame(0, 8'h00, urb, 1'b1, 1'b0);

    // R1: reset in mid-frame
    repeat (30) @(negedge clk);
    s_data = 8'h3C; s_last = 1'b1; s_valid = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    s_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!tx_en && txd == 2'b00 && !s_ready && !tx_underrun, "R1",
        "outputs after mid-frame reset", {tx_en, txd, s_ready, tx_underrun}, 0);
    rst = 1'b0;
    nd = 0;
    @(negedge clk);
    send_frame(2, 8'h96, 0, 1'b0);

    chk(idle_bad == 0, "R6", "nonzero txd while idle", idle_bad, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule